// File: doc/BRIEF.md
# ARINC 429 Word Transmitter with Queue

This block takes 31-bit ARINC 429 words from a 16-bit host bus and sends them on a serial line. A host writes each word as two single-cycle byte strobes, low half first and then high half. The assembled word enters an eight-entry first-in first-out queue. While the transmit enable is high, the block takes words from the queue one at a time. It adds a parity bit and shifts the word out as bit 1 first on two return-to-zero lines. One line carries the ones and the other carries the zeroes.

Bit timing is derived from the master clock. In fast mode a bit cell lasts 10 clocks and the word gap lasts 40. In slow mode these times are eight times longer. A divided data clock is brought out, and a ready flag shows when the queue is empty and the last word, including its gap, has left the line. An asynchronous active-low reset stops the line at once and empties the queue.

Top module: `a429_xmit`

## Requirements
- R1: A word is written to the queue only when a `load_hi` strobe follows a `load_lo` strobe. A second `load_lo` before `load_hi` replaces the held low half. A `load_hi` with no low half held loads nothing.
- R2: The ARINC bit k is bit k-1 of the sent frame. The low half maps bus bits 7..0 to ARINC bits 1..8, bus bits 11..15 to ARINC bits 9..13, bus bit 9 to ARINC bit 30 and bus bit 10 to ARINC bit 31. Bus bit 8 is ignored. The high half maps bus bits 0..15 to ARINC bits 14..29.
- R3: The queue holds 8 words and sends them in load order. Loads made while it holds 8 words are dropped.
- R4: `tx_ready` is 1 after reset. It is 0 from the clock edge that writes a word. It returns to 1 only when the queue is empty and the word gap of the last word has ended.
- R5: ARINC bit 32 makes the number of ones in all 32 bits odd when `par_even`=0 and even when `par_even`=1. `par_even` is sampled when a word starts.
- R6: A word starts only while `tx_en` is 1. The first pulse appears within 2.5 data-clock periods of `tx_en` rising. A word in progress always completes.
- R7: In fast mode (`rate_slow`=0) each bit drives its line for 5 clocks and then is null for 5 clocks. When words follow back to back, the null between the last pulse of one word and the first pulse of the next is 45 clocks (5 plus a 40-clock gap).
- R8: In slow mode (`rate_slow`=1) the pulse is 40 clocks, the null is 40 clocks and the word gap is 320 clocks, giving 360 null clocks between words. The mode is sampled when a word starts.
- R9: A 1 bit raises `line_one`, a 0 bit raises `line_zero`, and both lines are never high together. Both lines are low during null, gap and idle.
- R10: `bit_clk` is the master clock divided by 10 (`rate_slow`=0) or by 80 (`rate_slow`=1), high for the first half of each period.
- R11: While `rst_n` is low, both lines are low and `tx_ready` is 1 without waiting for a clock edge. Reset discards queued words and any held low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 16 | Host data for both halves of a word |
| load_lo | input | 1 | Single-cycle strobe capturing the low half |
| load_hi | input | 1 | Single-cycle strobe capturing the high half and writing the word |
| tx_en | input | 1 | Permits words to start on the line |
| par_even | input | 1 | 0: odd total parity, 1: even total parity |
| rate_slow | input | 1 | 0: fast bit timing, 1: slow bit timing |
| line_one | output | 1 | Return-to-zero line for one bits |
| line_zero | output | 1 | Return-to-zero line for zero bits |
| bit_clk | output | 1 | Divided data clock |
| tx_ready | output | 1 | Queue empty and line finished |

## Verification
The line is decoded pulse by pulse. Words with dense, sparse and bit-position-distinct patterns are sent, and each decoded frame is compared with a frame built from the bus layout; this separates mapping errors from parity-sense errors. Queued bursts loaded before enable expose the back-to-back gap length and the order of the queue. A ten-word burst and orphan or repeated low-half strobes show what is dropped and what is replaced. Slow-mode bursts and a reset in mid-word separate the two timing sets and show that reset empties the queue.

// File: rtl/a429_xmit_pkg.sv
package a429_xmit_pkg;

   localparam int unsigned WORD_W  = 31;
   localparam int unsigned HALF_W  = 16;
   localparam int unsigned LO_KEEP = 15;

   typedef logic [WORD_W-1:0]  a429_word_t;
   typedef logic [LO_KEEP-1:0] lo_half_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_DRIVE = 2'd1,
      SQ_NULL  = 2'd2,
      SQ_GAP   = 2'd3
   } sq_state_e;

   // lo holds bus bits {15..9, 7..0}; bus bit 8 is never kept.
   function automatic a429_word_t pack_word(input lo_half_t lo, input logic [HALF_W-1:0] hi);
      a429_word_t w;
      w = '0;
      for (int i = 0; i < 8; i++) begin
         w[i] = lo[7-i];
      end
      w[12:8]  = lo[14:10];
      w[28:13] = hi;
      w[30:29] = lo[9:8];
      return w;
   endfunction

endpackage

// File: rtl/a429_xmit_loader.sv
module a429_xmit_loader
   import a429_xmit_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] bus_i,
   input  logic              ld_lo_i,
   input  logic              ld_hi_i,
   output logic              wr_o,
   output a429_word_t        wdata_o
);

   lo_half_t lo_q;
   logic     lo_vld_q;
   logic     unused_bus_b8;

   assign unused_bus_b8 = bus_i[8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q     <= '0;
         lo_vld_q <= 1'b0;
      end else if (ld_lo_i) begin
         lo_q     <= {bus_i[15:9], bus_i[7:0]};
         lo_vld_q <= 1'b1;
      end else if (ld_hi_i) begin
         lo_vld_q <= 1'b0;
      end
   end

   assign wr_o    = ld_hi_i & lo_vld_q;
   assign wdata_o = pack_word(lo_q, bus_i);

endmodule

// File: rtl/a429_xmit_fifo.sv
module a429_xmit_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned WIDTH = 31
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_i,
   input  logic [WIDTH-1:0]             wdata_i,
   input  logic                         rd_i,
   output logic [WIDTH-1:0]             rdata_o,
   output logic                         empty_o,
   output logic [$clog2(DEPTH+1)-1:0]   count_o
);

   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
   localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0]    cnt_q;
   logic             full, wr_ok, rd_ok;

   assign full    = (cnt_q == CNT_FULL);
   assign empty_o = (cnt_q == '0);
   assign wr_ok   = wr_i & ~full;
   assign rd_ok   = rd_i & ~empty_o;
   assign count_o = cnt_q;
   assign rdata_o = mem_q[rp_q];

   generate
      if (POW2) begin : g_ptr_wrap
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_ptr_cmp
         assign wp_nx = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) begin
         mem_q[wp_q] <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_ok) wp_q <= wp_nx;
         if (rd_ok) rp_q <= rp_nx;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/a429_xmit_par.sv
module a429_xmit_par
   import a429_xmit_pkg::*;
(
   input  a429_word_t word_i,
   input  logic       even_i,
   output logic       par_o
);

   logic ones_odd;

   assign ones_odd = ^word_i;
   // odd sense needs a 1 when the data ones are even in number
   assign par_o    = even_i ? ones_odd : ~ones_odd;

endmodule

// File: rtl/a429_xmit_seq.sv
module a429_xmit_seq
   import a429_xmit_pkg::*;
#(
   parameter int unsigned HALF_FAST = 5,
   parameter int unsigned HALF_SLOW = 40,
   parameter int unsigned GAP_BITS  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en_i,
   input  logic       slow_sel_i,
   input  logic       par_even_i,
   input  logic       fifo_empty_i,
   input  a429_word_t fifo_rdata_i,
   output logic       pop_o,
   output logic       busy_o,
   output logic       line_one_o,
   output logic       line_zero_o
);

   localparam int unsigned GAP_FAST = GAP_BITS * 2 * HALF_FAST;
   localparam int unsigned GAP_SLOW = GAP_BITS * 2 * HALF_SLOW;
   localparam int unsigned TMR_TOP  = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
   localparam int unsigned TW       = $clog2(TMR_TOP + 1);
   localparam int unsigned FRAME_W  = WORD_W + 1;
   localparam int unsigned BW       = $clog2(FRAME_W);
   localparam logic [TW-1:0] HF_LD  = TW'(HALF_FAST - 1);
   localparam logic [TW-1:0] HS_LD  = TW'(HALF_SLOW - 1);
   localparam logic [TW-1:0] GF_LD  = TW'(GAP_FAST - 1);
   localparam logic [TW-1:0] GS_LD  = TW'(GAP_SLOW - 1);
   localparam logic [BW-1:0] LAST_B = BW'(FRAME_W - 1);

   sq_state_e          state_q;
   logic [TW-1:0]      tmr_q;
   logic [BW-1:0]      bit_q;
   logic [FRAME_W-1:0] shr_q;
   logic               slow_q;
   logic               par_bit, tmr_done, launch;
   logic [TW-1:0]      half_ld, gap_ld, start_ld;

   a429_xmit_par u_par (
      .word_i (fifo_rdata_i),
      .even_i (par_even_i),
      .par_o  (par_bit)
   );

   assign tmr_done = (tmr_q == '0);
   assign half_ld  = slow_q ? HS_LD : HF_LD;
   assign gap_ld   = slow_q ? GS_LD : GF_LD;
   assign start_ld = slow_sel_i ? HS_LD : HF_LD;
   assign launch   = tx_en_i & ~fifo_empty_i &
                     ((state_q == SQ_IDLE) | ((state_q == SQ_GAP) & tmr_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         tmr_q   <= '0;
         bit_q   <= '0;
         shr_q   <= '0;
         slow_q  <= 1'b0;
      end else if (launch) begin
         state_q <= SQ_DRIVE;
         tmr_q   <= start_ld;
         bit_q   <= '0;
         shr_q   <= {par_bit, fifo_rdata_i};
         slow_q  <= slow_sel_i;
      end else begin
         case (state_q)
            SQ_DRIVE: begin
               if (tmr_done) begin
                  state_q <= SQ_NULL;
                  tmr_q   <= half_ld;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            SQ_NULL: begin
               if (!tmr_done) begin
                  tmr_q <= tmr_q - 1'b1;
               end else if (bit_q == LAST_B) begin
                  state_q <= SQ_GAP;
                  tmr_q   <= gap_ld;
               end else begin
                  state_q <= SQ_DRIVE;
                  tmr_q   <= half_ld;
                  bit_q   <= bit_q + 1'b1;
                  shr_q   <= {1'b0, shr_q[FRAME_W-1:1]};
               end
            end
            SQ_GAP: begin
               if (tmr_done) begin
                  state_q <= SQ_IDLE;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign pop_o       = launch;
   assign busy_o      = (state_q != SQ_IDLE);
   assign line_one_o  = (state_q == SQ_DRIVE) &  shr_q[0];
   assign line_zero_o = (state_q == SQ_DRIVE) & ~shr_q[0];

endmodule

// File: rtl/a429_xmit_clkdiv.sv
module a429_xmit_clkdiv #(
   parameter int unsigned HALF_FAST = 5,
   parameter int unsigned HALF_SLOW = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_sel_i,
   output logic dclk_o
);

   localparam int unsigned TOP = (HALF_SLOW > HALF_FAST) ? 2 * HALF_SLOW : 2 * HALF_FAST;
   localparam int unsigned CW  = $clog2(TOP);
   localparam logic [CW-1:0] LIM_F  = CW'(2 * HALF_FAST - 1);
   localparam logic [CW-1:0] LIM_S  = CW'(2 * HALF_SLOW - 1);
   localparam logic [CW-1:0] HALF_F = CW'(HALF_FAST);
   localparam logic [CW-1:0] HALF_S = CW'(HALF_SLOW);

   logic [CW-1:0] cnt_q, lim, half;

   assign lim  = slow_sel_i ? LIM_S : LIM_F;
   assign half = slow_sel_i ? HALF_S : HALF_F;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q >= lim) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign dclk_o = (cnt_q < half);

endmodule

// File: rtl/a429_xmit.sv
module a429_xmit
   import a429_xmit_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned HALF_FAST  = 5,
   parameter int unsigned HALF_SLOW  = 40,
   parameter int unsigned GAP_BITS   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] bus_data,
   input  logic        load_lo,
   input  logic        load_hi,
   input  logic        tx_en,
   input  logic        par_even,
   input  logic        rate_slow,
   output logic        line_one,
   output logic        line_zero,
   output logic        bit_clk,
   output logic        tx_ready
);

   localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("a429_xmit: FIFO_DEPTH must be at least 2");
      end
      if (HALF_FAST < 2 || HALF_SLOW < 2) begin : g_bad_half
         $error("a429_xmit: half-bit lengths must be at least 2 clocks");
      end
      if (GAP_BITS < 1) begin : g_bad_gap
         $error("a429_xmit: GAP_BITS must be at least 1");
      end
   endgenerate

   logic             wr_req, pop, fifo_empty, seq_busy;
   a429_word_t       wr_word, rd_word;
   logic [CNT_W-1:0] fifo_cnt;

   a429_xmit_loader u_loader (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_i   (bus_data),
      .ld_lo_i (load_lo),
      .ld_hi_i (load_hi),
      .wr_o    (wr_req),
      .wdata_o (wr_word)
   );

   a429_xmit_fifo #(
      .DEPTH (FIFO_DEPTH),
      .WIDTH (WORD_W)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_req),
      .wdata_i (wr_word),
      .rd_i    (pop),
      .rdata_o (rd_word),
      .empty_o (fifo_empty),
      .count_o (fifo_cnt)
   );

   a429_xmit_seq #(
      .HALF_FAST (HALF_FAST),
      .HALF_SLOW (HALF_SLOW),
      .GAP_BITS  (GAP_BITS)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_en_i      (tx_en),
      .slow_sel_i   (rate_slow),
      .par_even_i   (par_even),
      .fifo_empty_i (fifo_empty),
      .fifo_rdata_i (rd_word),
      .pop_o        (pop),
      .busy_o       (seq_busy),
      .line_one_o   (line_one),
      .line_zero_o  (line_zero)
   );

   a429_xmit_clkdiv #(
      .HALF_FAST (HALF_FAST),
      .HALF_SLOW (HALF_SLOW)
   ) u_clkdiv (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_sel_i (rate_slow),
      .dclk_o     (bit_clk)
   );

   assign tx_ready = (fifo_cnt == '0) & ~seq_busy;

endmodule

// File: rtl/a429_xmit_chk.sv
module a429_xmit_chk #(
   parameter int unsigned DEPTH = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tx_en,
   input logic                       line_one,
   input logic                       line_zero,
   input logic                       tx_ready,
   input logic                       wr_req,
   input logic                       pop,
   input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);

   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   p_lines_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_one && line_zero));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (!line_one && !line_zero));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= FULL);

   p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_cnt == FULL && wr_req && !pop) |=> (fifo_cnt == FULL));

   p_ready_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && fifo_cnt != FULL) |=> !tx_ready);

   p_ready_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (fifo_cnt == '0));

   p_pop_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> tx_en);

   p_pulse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_one) |=> line_one);

endmodule

bind a429_xmit a429_xmit_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_en     (tx_en),
   .line_one  (line_one),
   .line_zero (line_zero),
   .tx_ready  (tx_ready),
   .wr_req    (wr_req),
   .pop       (pop),
   .fifo_cnt  (fifo_cnt)
);

// File: tb/a429_xmit_bench.sv
`timescale 1ns/1ps
module a429_xmit_bench;

   localparam int WD_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_data = '0;
   logic        load_lo = 1'b0, load_hi = 1'b0, tx_en = 1'b0;
   logic        par_even = 1'b0, rate_slow = 1'b0;
   logic        line_one, line_zero, bit_clk, tx_ready;

   int checks = 0, errors = 0;
   int cyc = 0;
   int exp_half = 5;

   // line monitor state
   logic        mon_clr = 1'b0;
   logic [1:0]  prev_ln = 2'b00;
   int          run_len = 0, bidx = 0, tim_err = 0, last_gap = 0;
   int          first_cyc = 0;
   bit          first_seen = 1'b0;
   logic [31:0] cur_word = '0;
   logic [31:0] rx_q[$];
   logic        prev_dclk = 1'b0;
   int          drun = 0, last_dhi = 0, last_dlo = 0;

   always #2.5 clk = ~clk;

   a429_xmit u_a429_xmit (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_data  (bus_data),
      .load_lo   (load_lo),
      .load_hi   (load_hi),
      .tx_en     (tx_en),
      .par_even  (par_even),
      .rate_slow (rate_slow),
      .line_one  (line_one),
      .line_zero (line_zero),
      .bit_clk   (bit_clk),
      .tx_ready  (tx_ready)
   );

   always @(negedge clk) begin
      logic [1:0] cur;
      cyc = cyc + 1;
      if (cyc == WD_LIMIT) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
      if (bit_clk != prev_dclk) begin
         if (prev_dclk) last_dhi = drun; else last_dlo = drun;
         drun = 1;
      end else begin
         drun = drun + 1;
      end
      prev_dclk = bit_clk;
      if (mon_clr) begin
         bidx = 0; tim_err = 0; run_len = 0; prev_ln = 2'b00;
         first_seen = 1'b0; last_gap = 0; cur_word = '0;
         rx_q.delete();
      end else begin
         cur = {line_one, line_zero};
         if (cur == 2'b11) tim_err = tim_err + 1;
         if (cur != prev_ln) begin
            if (prev_ln == 2'b00) begin
               if (!first_seen) begin
                  first_seen = 1'b1;
                  first_cyc  = cyc;
               end else if (bidx == 0) begin
                  last_gap = run_len;
               end else if (run_len != exp_half) begin
                  tim_err = tim_err + 1;
               end
            end else begin
               if (run_len != exp_half) tim_err = tim_err + 1;
               cur_word[bidx] = prev_ln[1];
               bidx = bidx + 1;
               if (bidx == 32) begin
                  rx_q.push_back(cur_word);
                  bidx = 0;
               end
            end
            run_len = 1;
         end else begin
            run_len = run_len + 1;
         end
         prev_ln = cur;
      end
   end

   function automatic logic [31:0] exp_word(input logic [15:0] lo, input logic [15:0] hi,
                                            input logic even);
      logic [31:0] w;
      w = '0;
      for (int i = 0; i < 8; i++) w[i] = lo[7-i];
      for (int j = 0; j < 5; j++) w[8+j] = lo[11+j];
      for (int j = 0; j < 16; j++) w[13+j] = hi[j];
      w[29] = lo[9];
      w[30] = lo[10];
      w[31] = even ? (^w[30:0]) : ~(^w[30:0]);
      return w;
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(negedge clk) mon_clr = 1'b1;
      @(negedge clk) mon_clr = 1'b0;
   endtask

   task automatic strobe_lo(input logic [15:0] d);
      @(negedge clk) begin bus_data = d; load_lo = 1'b1; end
      @(negedge clk) load_lo = 1'b0;
   endtask

   task automatic strobe_hi(input logic [15:0] d);
      @(negedge clk) begin bus_data = d; load_hi = 1'b1; end
      @(negedge clk) load_hi = 1'b0;
   endtask

   task automatic load_word(input logic [15:0] lo, input logic [15:0] hi);
      strobe_lo(lo);
      strobe_hi(hi);
   endtask

   task automatic wait_ready(input int limit);
      for (int n = 0; n < limit; n++) begin
         @(negedge clk);
         if (tx_ready) break;
      end
   endtask

   task automatic t_reset();
      chk(tx_ready === 1'b1, "R11 ready after reset", {31'd0, tx_ready}, 32'd1);
      chk({line_one, line_zero} === 2'b00, "R11 lines low after reset", {30'd0, line_one, line_zero}, 32'd0);
   endtask

   task automatic t_single_fast();
      logic [31:0] e;
      int en_cyc;
      rate_slow = 1'b0; exp_half = 5; par_even = 1'b0;
      clear_mon();
      load_word(16'hA5C3, 16'h1E7F);
      @(negedge clk);
      chk(tx_ready === 1'b0, "R4 ready low after load", {31'd0, tx_ready}, 32'd0);
      chk({line_one, line_zero} === 2'b00, "R6 no output while disabled", {30'd0, line_one, line_zero}, 32'd0);
      @(negedge clk) begin tx_en = 1'b1; en_cyc = cyc; end
      wait_ready(2000);
      tx_en = 1'b0;
      e = exp_word(16'hA5C3, 16'h1E7F, 1'b0);
      chk(rx_q.size() == 1, "R1 one word sent", rx_q.size(), 1);
      if (rx_q.size() > 0) chk(rx_q[0] === e, "R2 R5 R9 word and odd parity", rx_q[0], e);
      chk(first_cyc - en_cyc <= 25, "R6 first pulse latency", first_cyc - en_cyc, 25);
      chk(tim_err == 0, "R7 fast pulse and null widths", tim_err, 0);
      chk(tx_ready === 1'b1, "R4 ready back high", {31'd0, tx_ready}, 32'd1);
      chk(last_dhi == 5 && last_dlo == 5, "R10 bit_clk divide by 10",
          {last_dhi[15:0], last_dlo[15:0]}, {16'd5, 16'd5});
   endtask

   task automatic t_even_parity();
      logic [31:0] e;
      par_even = 1'b1;
      clear_mon();
      load_word(16'h0001, 16'h0000);
      load_word(16'hFFFF, 16'hFFFF);
      @(negedge clk) tx_en = 1'b1;
      wait_ready(3000);
      tx_en = 1'b0;
      chk(rx_q.size() == 2, "R5 two even-parity words", rx_q.size(), 2);
      e = exp_word(16'h0001, 16'h0000, 1'b1);
      if (rx_q.size() > 0) chk(rx_q[0] === e, "R5 even parity sparse word", rx_q[0], e);
      e = exp_word(16'hFFFF, 16'hFFFF, 1'b1);
      if (rx_q.size() > 1) chk(rx_q[1] === e, "R2 R5 dense word, bus bit 8 dropped", rx_q[1], e);
      par_even = 1'b0;
   endtask

   task automatic t_burst_gap();
      logic [15:0] lo [3] = '{16'h1234, 16'h8001, 16'h4C2D};
      logic [15:0] hi [3] = '{16'hFEDC, 16'h0F0F, 16'hB00B};
      clear_mon();
      for (int k = 0; k < 3; k++) load_word(lo[k], hi[k]);
      repeat (100) @(negedge clk);
      chk(rx_q.size() == 0 && !first_seen, "R6 nothing sent with enable low", rx_q.size(), 0);
      @(negedge clk) tx_en = 1'b1;
      wait_ready(4000);
      tx_en = 1'b0;
      chk(rx_q.size() == 3, "R3 burst count", rx_q.size(), 3);
      for (int k = 0; k < 3; k++)
         if (rx_q.size() > k)
            chk(rx_q[k] === exp_word(lo[k], hi[k], 1'b0), "R3 burst order", rx_q[k], exp_word(lo[k], hi[k], 1'b0));
      chk(last_gap == 45, "R7 back-to-back null 45", last_gap, 45);
      chk(tim_err == 0, "R7 burst timing", tim_err, 0);
   endtask

   task automatic t_full();
      clear_mon();
      for (int k = 0; k < 10; k++) load_word(16'h0100 + 16'(k), 16'h5A00 + 16'(k));
      @(negedge clk) tx_en = 1'b1;
      wait_ready(8000);
      tx_en = 1'b0;
      chk(rx_q.size() == 8, "R3 only 8 words kept", rx_q.size(), 8);
      for (int k = 0; k < 8; k++)
         if (rx_q.size() > k)
            chk(rx_q[k] === exp_word(16'h0100 + 16'(k), 16'h5A00 + 16'(k), 1'b0), "R3 kept words in order",
                rx_q[k], exp_word(16'h0100 + 16'(k), 16'h5A00 + 16'(k), 1'b0));
   endtask

   task automatic t_strobe_rules();
      logic [31:0] e;
      clear_mon();
      strobe_hi(16'h7777);
      @(negedge clk);
      chk(tx_ready === 1'b1, "R1 lone high strobe loads nothing", {31'd0, tx_ready}, 32'd1);
      strobe_lo(16'h00FF);
      strobe_lo(16'h3C81);
      strobe_hi(16'h2468);
      @(negedge clk) tx_en = 1'b1;
      wait_ready(2000);
      tx_en = 1'b0;
      e = exp_word(16'h3C81, 16'h2468, 1'b0);
      chk(rx_q.size() == 1, "R1 one word after repeated low strobe", rx_q.size(), 1);
      if (rx_q.size() > 0) chk(rx_q[0] === e, "R1 newer low half used", rx_q[0], e);
   endtask

   task automatic t_slow();
      rate_slow = 1'b1; exp_half = 40;
      repeat (200) @(negedge clk);
      chk(last_dhi == 40 && last_dlo == 40, "R10 bit_clk divide by 80",
          {last_dhi[15:0], last_dlo[15:0]}, {16'd40, 16'd40});
      clear_mon();
      load_word(16'hC0DE, 16'h9ABC);
      load_word(16'h0F1E, 16'h4321);
      @(negedge clk) tx_en = 1'b1;
      wait_ready(8000);
      tx_en = 1'b0;
      chk(rx_q.size() == 2, "R8 slow word count", rx_q.size(), 2);
      if (rx_q.size() > 1) chk(rx_q[1] === exp_word(16'h0F1E, 16'h4321, 1'b0), "R8 slow word content",
                               rx_q[1], exp_word(16'h0F1E, 16'h4321, 1'b0));
      chk(last_gap == 360, "R8 slow null between words", last_gap, 360);
      chk(tim_err == 0, "R8 slow pulse and null widths", tim_err, 0);
      rate_slow = 1'b0; exp_half = 5;
   endtask

   task automatic t_reset_mid();
      clear_mon();
      load_word(16'hAAAA, 16'h5555);
      load_word(16'h1111, 16'h2222);
      strobe_lo(16'h9999);
      @(negedge clk) tx_en = 1'b1;
      repeat (100) @(negedge clk);
      chk(first_seen, "R11 transmission was under way", {31'd0, first_seen}, 32'd1);
      rst_n = 1'b0;
      tx_en = 1'b0;
      #1;
      chk({line_one, line_zero} === 2'b00, "R11 lines low at once", {30'd0, line_one, line_zero}, 32'd0);
      chk(tx_ready === 1'b1, "R11 ready high at once", {31'd0, tx_ready}, 32'd1);
      @(negedge clk) rst_n = 1'b1;
      clear_mon();
      strobe_hi(16'h7E7E);
      @(negedge clk) tx_en = 1'b1;
      repeat (600) @(negedge clk);
      tx_en = 1'b0;
      chk(rx_q.size() == 0 && !first_seen, "R11 queue and held low half discarded", rx_q.size(), 0);
      chk(tx_ready === 1'b1, "R11 ready stays high", {31'd0, tx_ready}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      repeat (30) @(negedge clk);
      t_single_fast();
      t_even_parity();
      t_burst_gap();
      t_full();
      t_strobe_rules();
      t_slow();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule